// File: doc/BRIEF.md
# SPI Control-Word Slave with Flow Control

This block lets an external host exchange 32-bit control words with on-chip logic over a four-wire serial link running in SPI mode 0 (the host samples on the rising SCLK edge, both sides change data on the falling edge, and SCLK idles low). Every frame opens with one command byte. Its upper seven bits carry the device address and its lowest bit selects the direction. After that byte, a write frame carries whole 32-bit words into the chip and a read frame carries them out. Words travel most-significant byte first, and the bits within each byte also go most-significant first.

The serial inputs are brought into the system clock domain through a synchronizer, so SCLK must be well below the system clock rate. Completed write words go into a small buffer. The internal side drains that buffer with a valid/ready handshake. While the buffer is full, an active-low busy line tells the host to pause. Read words come from an internal source that shows a not-empty flag. The block pulls one word from that source at each word boundary of a read frame. An active-low interrupt shows whether read data is still waiting, and the host keeps reading 4-byte groups until the interrupt releases.

Top module: `spi_cw_slave`

## Requirements
- R1: The command byte is the first byte after CS falls. Value 0x80 (address 0x40, direction bit 0) opens a write frame and 0x81 (direction bit 1) opens a read frame. Any other value makes the rest of the frame ignored: no word is written and MISO shifts only zeros.
- R2: MOSI is sampled on rising SCLK edges and MISO changes on falling SCLK edges. Each byte is sent bit 7 first, and each word is sent with bits 31..24 first and bits 7..0 last.
- R3: In a write frame, every 32 bits after the command byte form one word on wr_data/wr_valid. A frame may hold several words, and they come out in the order received. wr_valid and wr_data hold steady while wr_ready is low.
- R4: In a read frame, at the start of each word the block takes one word from the read source when rd_avail is high, pulsing rd_take for one cycle, and shifts that word out. When rd_avail is low it shifts out zeros and does not pulse rd_take.
- R5: irq_n is the inverse of rd_avail, registered with one cycle of delay.
- R6: busy_n is low exactly while the write buffer holds WBUF_DEPTH words. A word that completes while the buffer is full is dropped.
- R7: CS going high in the middle of a word discards the partial word. The next frame starts again with a command byte.
- R8: spi_miso_oe follows the inverse of spi_cs_n two clock cycles later. spi_miso is 0 whenever spi_miso_oe is low.
- R9: After reset: wr_valid, rd_take and spi_miso_oe are 0, and busy_n and irq_n are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select from host, active low |
| spi_sclk | input | 1 | Serial clock from host, idles low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Pad enable for MISO; when low the pad is high impedance |
| irq_n | output | 1 | Low while read data is pending |
| busy_n | output | 1 | Low while the host must pause |
| wr_valid | output | 1 | Write word available |
| wr_ready | input | 1 | Internal consumer accepts the write word |
| wr_data | output | WORD_W | Write word |
| rd_avail | input | 1 | Read source not empty |
| rd_data | input | WORD_W | Head word of the read source |
| rd_take | output | 1 | One-cycle pop strobe to the read source |

## Verification
On every cycle, the assertions check how MISO enable follows CS, that MISO stays quiet when it is not driven, the one-cycle relation between irq_n and rd_avail, that a rd_take pulse is single and backed by rd_avail, that the write word holds while stalled, and that busy always comes with a buffered word. The bench's reference model also compares irq_n and MISO enable on every cycle. Only the scenarios can show the deeper behaviour: that the command byte is decoded, that bytes come in the right order across words in both directions, that zeros are shifted once the source is empty, that a word sent while busy is dropped, and that a frame aborted mid-word leaves nothing behind.

// File: rtl/spi_cw_pkg.sv
package spi_cw_pkg;
   typedef enum logic [1:0] {
      PH_CMD  = 2'd0,
      PH_WR   = 2'd1,
      PH_RD   = 2'd2,
      PH_SKIP = 2'd3
   } phase_t;

   localparam int unsigned CMD_BITS = 8;
endpackage

// File: rtl/spi_cw_sync.sv
module spi_cw_sync #(
   parameter int unsigned N      = 3,
   parameter int unsigned STAGES = 2,
   parameter logic [N-1:0] RST   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] din,
   output logic [N-1:0] dout
);
   initial begin
      assert (STAGES >= 2) else $error("spi_cw_sync: STAGES must be at least 2");
   end

   logic [N-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST;
      end else begin
         stg[0] <= din;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign dout = stg[STAGES-1];
endmodule

// File: rtl/spi_cw_wbuf.sv
module spi_cw_wbuf #(
   parameter int unsigned W     = 32,
   parameter int unsigned DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   output logic         full,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data
);
   localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH + 1);

   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("spi_cw_wbuf: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp;
   logic [CW-1:0] fill;
   logic          do_push, do_pop;

   assign full      = (fill == CW'(DEPTH));
   assign out_valid = (fill != '0);
   assign out_data  = mem[rp];
   assign do_push   = push && !full;
   assign do_pop    = out_valid && out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp   <= '0;
         rp   <= '0;
         fill <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         case ({do_push, do_pop})
            2'b10:   fill <= fill + 1'b1;
            2'b01:   fill <= fill - 1'b1;
            default: fill <= fill;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= push_data;
   end
endmodule

// File: rtl/spi_cw_frame.sv
module spi_cw_frame
   import spi_cw_pkg::*;
#(
   parameter int unsigned WORD_W   = 32,
   parameter logic [6:0]  DEV_ADDR = 7'h40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n_s,
   input  logic              sclk_s,
   input  logic              mosi_s,
   input  logic              rd_avail,
   input  logic [WORD_W-1:0] rd_data,
   output logic              rd_take,
   output logic              push_valid,
   output logic [WORD_W-1:0] push_data,
   output logic              miso_bit
);
   localparam int unsigned CW        = $clog2(WORD_W);
   localparam logic [CW-1:0] CMD_END = CW'(CMD_BITS - 1);
   localparam logic [CW-1:0] WORD_END = CW'(WORD_W - 1);
   localparam logic [7:0] CMD_WR = {DEV_ADDR, 1'b0};
   localparam logic [7:0] CMD_RD = {DEV_ADDR, 1'b1};

   initial begin
      assert (WORD_W >= CMD_BITS && (WORD_W & (WORD_W - 1)) == 0)
         else $error("spi_cw_frame: WORD_W must be a power of two, at least 8");
   end

   phase_t            phase;
   logic              sclk_q;
   logic              rise, fall;
   logic [CW-1:0]     bit_cnt;
   logic [WORD_W-1:0] sh_in, sh_out;
   logic [WORD_W-1:0] sh_in_nxt;
   logic [7:0]        cmd_byte;

   assign rise      = sclk_s && !sclk_q && !cs_n_s;
   assign fall      = !sclk_s && sclk_q && !cs_n_s;
   assign sh_in_nxt = {sh_in[WORD_W-2:0], mosi_s};
   assign cmd_byte  = sh_in_nxt[7:0];
   assign miso_bit  = sh_out[WORD_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q     <= 1'b0;
         phase      <= PH_CMD;
         bit_cnt    <= '0;
         sh_in      <= '0;
         sh_out     <= '0;
         rd_take    <= 1'b0;
         push_valid <= 1'b0;
         push_data  <= '0;
      end else begin
         sclk_q     <= sclk_s;
         rd_take    <= 1'b0;
         push_valid <= 1'b0;
         if (cs_n_s) begin
            phase   <= PH_CMD;
            bit_cnt <= '0;
            sh_in   <= '0;
            sh_out  <= '0;
         end else if (rise) begin
            sh_in <= sh_in_nxt;
            if (phase == PH_CMD) begin
               if (bit_cnt == CMD_END) begin
                  bit_cnt <= '0;
                  if (cmd_byte == CMD_WR)      phase <= PH_WR;
                  else if (cmd_byte == CMD_RD) phase <= PH_RD;
                  else                         phase <= PH_SKIP;
               end else begin
                  bit_cnt <= bit_cnt + 1'b1;
               end
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
               if (phase == PH_WR && bit_cnt == WORD_END) begin
                  push_valid <= 1'b1;
                  push_data  <= sh_in_nxt;
               end
            end
         end else if (fall && phase == PH_RD) begin
            if (bit_cnt == '0) begin
               sh_out  <= rd_avail ? rd_data : '0;
               rd_take <= rd_avail;
            end else begin
               sh_out <= {sh_out[WORD_W-2:0], 1'b0};
            end
         end
      end
   end
endmodule

// File: rtl/spi_cw_slave.sv
module spi_cw_slave #(
   parameter int unsigned WORD_W      = 32,
   parameter int unsigned WBUF_DEPTH  = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [6:0]  DEV_ADDR    = 7'h40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_cs_n,
   input  logic              spi_sclk,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic              spi_miso_oe,
   output logic              irq_n,
   output logic              busy_n,
   output logic              wr_valid,
   input  logic              wr_ready,
   output logic [WORD_W-1:0] wr_data,
   input  logic              rd_avail,
   input  logic [WORD_W-1:0] rd_data,
   output logic              rd_take
);
   logic [2:0]        pins_s;
   logic              cs_n_s, sclk_s, mosi_s;
   logic              push_valid, buf_full, miso_bit;
   logic [WORD_W-1:0] push_data;

   spi_cw_sync #(
      .N      (3),
      .STAGES (SYNC_STAGES),
      .RST    (3'b100)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   ({spi_cs_n, spi_sclk, spi_mosi}),
      .dout  (pins_s)
   );

   assign {cs_n_s, sclk_s, mosi_s} = pins_s;

   spi_cw_frame #(
      .WORD_W   (WORD_W),
      .DEV_ADDR (DEV_ADDR)
   ) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_n_s     (cs_n_s),
      .sclk_s     (sclk_s),
      .mosi_s     (mosi_s),
      .rd_avail   (rd_avail),
      .rd_data    (rd_data),
      .rd_take    (rd_take),
      .push_valid (push_valid),
      .push_data  (push_data),
      .miso_bit   (miso_bit)
   );

   spi_cw_wbuf #(
      .W     (WORD_W),
      .DEPTH (WBUF_DEPTH)
   ) u_wbuf (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push_valid),
      .push_data (push_data),
      .full      (buf_full),
      .out_valid (wr_valid),
      .out_ready (wr_ready),
      .out_data  (wr_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_n <= 1'b1;
      else        irq_n <= !rd_avail;
   end

   assign busy_n      = !buf_full;
   assign spi_miso_oe = !cs_n_s;
   assign spi_miso    = spi_miso_oe && miso_bit;
endmodule

// File: rtl/spi_cw_checker.sv
module spi_cw_checker #(
   parameter int unsigned WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              spi_cs_n,
   input logic              spi_miso,
   input logic              spi_miso_oe,
   input logic              irq_n,
   input logic              busy_n,
   input logic              wr_valid,
   input logic              wr_ready,
   input logic [WORD_W-1:0] wr_data,
   input logic              rd_avail,
   input logic              rd_take
);
   p_oe_follows_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
      spi_miso_oe == !$past(spi_cs_n, 2));

   p_quiet_miso_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !spi_miso_oe |-> !spi_miso);

   p_irq_tracks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_n == !$past(rd_avail));

   p_take_backed_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_take |-> $past(rd_avail));

   p_take_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_take |=> !rd_take);

   p_hold_stalled_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data)));

   p_busy_has_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_n |-> wr_valid);
endmodule

bind spi_cw_slave spi_cw_checker #(.WORD_W(WORD_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .spi_cs_n    (spi_cs_n),
   .spi_miso    (spi_miso),
   .spi_miso_oe (spi_miso_oe),
   .irq_n       (irq_n),
   .busy_n      (busy_n),
   .wr_valid    (wr_valid),
   .wr_ready    (wr_ready),
   .wr_data     (wr_data),
   .rd_avail    (rd_avail),
   .rd_take     (rd_take)
);

// File: tb/spi_cw_slave_test.sv
`timescale 1ns/1ps
module spi_cw_slave_test;
   localparam int W = 32;
   localparam int H = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic spi_cs_n = 1'b1, spi_sclk = 1'b0, spi_mosi = 1'b0;
   logic spi_miso, spi_miso_oe, irq_n, busy_n, wr_valid, rd_take;
   logic wr_ready = 1'b1;
   logic rd_avail = 1'b0;
   logic [W-1:0] wr_data;
   logic [W-1:0] rd_data = '0;

   int total = 0, bad = 0;
   bit model_on = 0, obey = 1;
   logic [1:0] cs_hist = 2'b11;
   logic [W-1:0] rdq[$];
   logic [W-1:0] got[$];
   logic [W-1:0] expw[$];

   always #2 clk = ~clk;

   spi_cw_slave uut (
      .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
      .irq_n(irq_n), .busy_n(busy_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
      .wr_data(wr_data), .rd_avail(rd_avail), .rd_data(rd_data), .rd_take(rd_take)
   );

   task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                        input logic [W-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // cycle model: CS history through two stages, irq from source state
   always @(posedge clk) cs_hist <= {cs_hist[0], spi_cs_n};

   always @(negedge clk) begin
      if (model_on) begin
         check(spi_miso_oe == !cs_hist[1], "R8 oe", W'(spi_miso_oe), W'(!cs_hist[1]));
         check(irq_n == !rd_avail, "R5 irq", W'(irq_n), W'(!rd_avail));
         if (!spi_miso_oe) check(spi_miso == 1'b0, "R8 quiet", W'(spi_miso), '0);
      end
      if (wr_valid && wr_ready) got.push_back(wr_data);
      if (rd_take && rdq.size() != 0) void'(rdq.pop_front());
      rd_avail = (rdq.size() != 0);
      rd_data  = (rdq.size() != 0) ? rdq[0] : '0;
   end

   task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
      if (obey) while (!busy_n) @(negedge clk);
      for (int i = 7; i >= 0; i--) begin
         spi_mosi = tx[i];
         repeat (H) @(negedge clk);
         spi_sclk = 1'b1;
         rx[i] = spi_miso;
         repeat (H) @(negedge clk);
         spi_sclk = 1'b0;
      end
   endtask

   task automatic open_frame(input logic [7:0] cmd);
      logic [7:0] r;
      spi_cs_n = 1'b0;
      repeat (H) @(negedge clk);
      xbyte(cmd, r);
   endtask

   task automatic close_frame();
      repeat (H) @(negedge clk);
      spi_cs_n = 1'b1;
      repeat (4*H) @(negedge clk);
   endtask

   task automatic xword(input logic [W-1:0] tx, output logic [W-1:0] rx);
      logic [7:0] r;
      for (int b = 3; b >= 0; b--) begin
         xbyte(tx[b*8 +: 8], r);
         rx[b*8 +: 8] = r;
      end
   endtask

   task automatic cmp_writes(input string req);
      check(got.size() == expw.size(), req, W'(got.size()), W'(expw.size()));
      for (int i = 0; i < expw.size() && i < got.size(); i++)
         check(got[i] == expw[i], req, got[i], expw[i]);
   endtask

   initial begin
      logic [W-1:0] rx;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      check(!wr_valid, "R9 wr_valid", W'(wr_valid), '0);
      check(!rd_take, "R9 rd_take", W'(rd_take), '0);
      check(!spi_miso_oe, "R9 oe", W'(spi_miso_oe), '0);
      check(busy_n, "R9 busy_n", W'(busy_n), 1);
      check(irq_n, "R9 irq_n", W'(irq_n), 1);
      model_on = 1;

      // R1 R2 R3: write frame, two words
      open_frame(8'h80);
      xword(32'hA1B2C3D4, rx); expw.push_back(32'hA1B2C3D4);
      check(spi_miso_oe, "R8 oe in frame", W'(spi_miso_oe), 1);
      xword(32'h0F1E2D3C, rx); expw.push_back(32'h0F1E2D3C);
      close_frame();
      cmp_writes("R3 write words");

      // R4 R5 R2: read frame, two queued words then empty
      rdq.push_back(32'h8899AABB);
      rdq.push_back(32'h12345678);
      repeat (4) @(negedge clk);
      check(!irq_n, "R5 irq pending", W'(irq_n), 0);
      open_frame(8'h81);
      xword('0, rx);
      check(rx == 32'h8899AABB, "R4 read word 1", rx, 32'h8899AABB);
      check(!irq_n, "R5 irq still low", W'(irq_n), 0);
      xword('0, rx);
      check(rx == 32'h12345678, "R4 read word 2", rx, 32'h12345678);
      check(irq_n, "R5 irq released", W'(irq_n), 1);
      xword('0, rx);
      check(rx == '0, "R4 empty shifts zero", rx, '0);
      close_frame();
      check(rdq.size() == 0, "R4 pops", W'(rdq.size()), 0);

      // R1: foreign command byte ignored
      rdq.push_back(32'hDEADBEEF);
      open_frame(8'h22);
      xword(32'h55AA55AA, rx);
      check(rx == '0, "R1 foreign miso", rx, '0);
      close_frame();
      cmp_writes("R1 foreign no write");
      check(rdq.size() == 1, "R1 foreign no pop", W'(rdq.size()), 1);
      rdq.delete();
      repeat (4) @(negedge clk);

      // R6: buffer fills, busy, overrun word dropped
      wr_ready = 1'b0;
      open_frame(8'h80);
      xword(32'h11111111, rx); expw.push_back(32'h11111111);
      check(busy_n, "R6 busy high with room", W'(busy_n), 1);
      xword(32'h22222222, rx); expw.push_back(32'h22222222);
      repeat (H) @(negedge clk);
      check(!busy_n, "R6 busy low when full", W'(busy_n), 0);
      obey = 0;
      xword(32'h33333333, rx);
      obey = 1;
      close_frame();
      check(!busy_n, "R6 still full", W'(busy_n), 0);
      wr_ready = 1'b1;
      repeat (4) @(negedge clk);
      check(busy_n, "R6 busy released", W'(busy_n), 1);
      cmp_writes("R6 overrun dropped");

      // R7: abort mid-word then a clean frame
      open_frame(8'h80);
      begin
         logic [7:0] r;
         xbyte(8'h77, r);
         xbyte(8'h66, r);
      end
      close_frame();
      cmp_writes("R7 partial discarded");
      open_frame(8'h80);
      xword(32'hCAFEF00D, rx); expw.push_back(32'hCAFEF00D);
      close_frame();
      cmp_writes("R7 restart");

      model_on = 0;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule